// File: doc/BRIEF.md
# Clock-Synchronous Serial Shift Port

This block is an 8-bit serial port that transmits and receives at the same time on one shift clock. The shift clock comes from one of two sources. It can be an internally divided copy of the system clock, or an external clock that is synchronised into the system clock domain. A bus master sets the port up through a control register. It starts a transfer by writing the data register and reads the received byte back from that same register. A single-cycle interrupt request marks the end of each transfer of eight bits.

In internal-clock mode the shift clock can be presented on either of two clock pins, and the pin that is not selected is left undriven. The data output pin can drive both levels, or it can pull only low (open-drain). While the port is disabled, none of the pins are driven by the block. Each pin is modelled as separate input, output and output-enable signals.

Top module: `sync_shift_port`

## Requirements
- R1: The control register is at bus address 1 and the data register at address 0. Control fields: bits 2:0 divider code, bit 3 port enable, bit 4 open-drain, bit 5 MSB-first, bit 6 internal clock, bit 7 clock pin B. The control register reads back what was written and resets to 0x00. Reset also clears the data register and stops any transfer.
- R2: In internal mode the shift clock period is 8, 16, 32 or 64 system cycles for divider codes 000, 001, 010 and 011. It is 128 or 256 cycles for codes 110 and 111.
- R3: Divider codes 100 and 101 produce no shift clock. The clock pin stays high, no interrupt is raised and the data register is not shifted.
- R4: In internal mode a write to the data register starts a transfer. The interrupt pulse appears exactly 8 shift-clock periods after the clock edge that accepted the write.
- R5: Bit 5 = 0 sends the data register LSB first, and bit 5 = 1 sends it MSB first.
- R6: Input data is sampled on the rising shift-clock edge. After a transfer the data register holds the received byte: the first received bit is at bit 0 when sending LSB first and at bit 7 when sending MSB first.
- R7: The shift clock idles high. Data out changes only on a falling shift-clock edge.
- R8: With port enable and internal clock set, bit 7 = 0 drives the clock on pin A and bit 7 = 1 drives it on pin B. The other clock pin has its output enable low.
- R9: With port enable clear, the output enables of the data pin and of both clock pins stay low, and transfers still complete.
- R10: With open-drain clear the data pin output enable is high. With open-drain set the pin is enabled only to drive a 0 and is never driven high.
- R11: In external mode the clock input is taken from pin A (bit 7 = 0) or pin B (bit 7 = 1) and synchronised into the system clock domain. Shifting happens only on edges of that input after the data register has been written. Neither clock pin is driven.
- R12: The interrupt request is a one-cycle pulse issued after the eighth rising edge, once per transfer.
- R13: A write to the data register while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 data, 1 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| sdata_in | input | 1 | Serial data input |
| sdata_out | output | 1 | Serial data output level |
| sdata_oe | output | 1 | Serial data output enable |
| sclk_a_in | input | 1 | Clock pin A input |
| sclk_a_out | output | 1 | Clock pin A output level |
| sclk_a_oe | output | 1 | Clock pin A output enable |
| sclk_b_in | input | 1 | Clock pin B input |
| sclk_b_out | output | 1 | Clock pin B output level |
| sclk_b_oe | output | 1 | Clock pin B output enable |
| irq | output | 1 | Transfer-complete interrupt pulse |

## Verification
The assertions check the following on every cycle:
- the shift clock is high whenever no transfer is active;
- data out moves only on a falling edge;
- the interrupt is a single-cycle pulse that follows a rising edge;
- a reserved divider code freezes the clock;
- the open-drain pin is never driven high.

Only the bench scenarios can show the rest:
- the actual divider periods and the cycle count from the data write to the interrupt;
- the transmitted and received byte in both bit orders;
- pin steering;
- external-clock transfers on either pin;
- that a write made during a transfer is ignored.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  localparam int unsigned CTRL_W = 8;
  localparam int unsigned HALF_W = 8;

  typedef struct packed {
    logic       clk_pin_b;
    logic       int_clk;
    logic       msb_first;
    logic       open_drain;
    logic       port_en;
    logic [2:0] div_sel;
  } ssp_ctrl_t;

  // Half shift-clock period in system cycles; zero marks a reserved code.
  function automatic logic [HALF_W-1:0] half_period(input logic [2:0] code);
    logic [HALF_W-1:0] h;
    logic [2:0]        e;
    e = 3'd0;
    h = '0;
    if (code != 3'b100 && code != 3'b101) begin
      e = code[2] ? code : code + 3'd2;
      h = HALF_W'(1) << e;
    end
    return h;
  endfunction

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
  import ssp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       int_clk,
  input  logic [2:0] div_sel,
  input  logic       ext_clk,
  output logic       fall_ev,
  output logic       rise_ev,
  output logic       sclk
);

  localparam logic [HALF_W-1:0] H_ONE = HALF_W'(1);

  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              reserved, int_run, tick;
  logic              sclk_q, sclk_d;
  logic [2:0]        sync_q, sync_d;
  logic              ext_fall, ext_rise;

  always_comb begin
    half     = half_period(div_sel);
    reserved = (half == '0);
    int_run  = run & int_clk & ~reserved;
    tick     = int_run & (cnt_q == half - H_ONE);

    cnt_d = cnt_q;
    if (!int_run || tick) cnt_d = '0;
    else                  cnt_d = cnt_q + H_ONE;

    sclk_d = sclk_q;
    if (!run)      sclk_d = 1'b1;
    else if (tick) sclk_d = ~sclk_q;

    sync_d   = {sync_q[1:0], ext_clk};
    ext_fall = sync_q[2] & ~sync_q[1];
    ext_rise = ~sync_q[2] & sync_q[1];

    fall_ev = int_clk ? (tick & sclk_q)  : (run & ext_fall);
    rise_ev = int_clk ? (tick & ~sclk_q) : (run & ext_rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
      sync_q <= 3'b111;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      sync_q <= sync_d;
    end
  end

  assign sclk = sclk_q;

  // R3
  reserved_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && int_clk && reserved) |=> $stable(sclk_q));

  // R7
  fall_from_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |-> sclk_q);

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              msb_first,
  input  logic              fall_ev,
  input  logic              rise_ev,
  input  logic              sin,
  output logic              busy,
  output logic [DATA_W-1:0] data,
  output logic              dout,
  output logic              done
);

  localparam int unsigned      CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [DATA_W-1:0] sr_q, sr_d, shifted;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic              dout_q, dout_d;
  logic              done_q, done_d;
  logic              shift_en, drive_en, last;

  always_comb begin
    shift_en = busy_q & rise_ev;
    drive_en = busy_q & fall_ev;
    last     = (cnt_q == CNT_LAST);
    shifted  = msb_first ? {sr_q[DATA_W-2:0], sin} : {sin, sr_q[DATA_W-1:1]};

    sr_d   = sr_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    dout_d = dout_q;
    done_d = 1'b0;

    if (load) begin
      sr_d   = load_data;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (shift_en) begin
      sr_d   = shifted;
      cnt_d  = last ? '0 : cnt_q + CNT_ONE;
      busy_d = ~last;
      done_d = last;
    end

    if (drive_en) dout_d = msb_first ? sr_q[DATA_W-1] : sr_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      dout_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      dout_q <= dout_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign data = sr_q;
  assign dout = dout_q;
  assign done = done_q;

  // R12
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R12
  irq_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(rise_ev));

  // R7
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(dout_q));

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              sdata_oe,
  input  logic              sclk_a_in,
  output logic              sclk_a_out,
  output logic              sclk_a_oe,
  input  logic              sclk_b_in,
  output logic              sclk_b_out,
  output logic              sclk_b_oe,
  output logic              irq
);

  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  ssp_ctrl_t         ctrl_q, ctrl_d;
  logic              busy, load, fall_ev, rise_ev, sclk, dout, done;
  logic              ext_pin, drive_clk;
  logic [DATA_W-1:0] data;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  always_comb begin
    ctrl_d = ctrl_q;
    if (bus_wr && bus_addr) ctrl_d = ssp_ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ctrl_q <= '0;
    else             ctrl_q <= ctrl_d;
  end

  assign load    = bus_wr & ~bus_addr & ~busy;
  assign ext_pin = ctrl_q.clk_pin_b ? sclk_b_in : sclk_a_in;

  ssp_clkgen u_clkgen (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (busy),
    .int_clk (ctrl_q.int_clk),
    .div_sel (ctrl_q.div_sel),
    .ext_clk (ext_pin),
    .fall_ev (fall_ev),
    .rise_ev (rise_ev),
    .sclk    (sclk)
  );

  ssp_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (load),
    .load_data (bus_wdata),
    .msb_first (ctrl_q.msb_first),
    .fall_ev   (fall_ev),
    .rise_ev   (rise_ev),
    .sin       (sdata_in),
    .busy      (busy),
    .data      (data),
    .dout      (dout),
    .done      (done)
  );

  always_comb begin
    drive_clk  = ctrl_q.port_en & ctrl_q.int_clk;
    sclk_a_oe  = drive_clk & ~ctrl_q.clk_pin_b;
    sclk_b_oe  = drive_clk & ctrl_q.clk_pin_b;
    sclk_a_out = sclk;
    sclk_b_out = sclk;
    sdata_out  = ctrl_q.open_drain ? 1'b0 : dout;
    sdata_oe   = ctrl_q.port_en & (ctrl_q.open_drain ? ~dout : 1'b1);
    bus_rdata  = bus_addr ? DATA_W'(ctrl_q) : data;
    irq        = done;
  end

  // R7
  clk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !busy |-> sclk);

  // R10
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctrl_q.port_en && ctrl_q.open_drain) |-> !(sdata_oe && sdata_out));

endmodule

// File: tb/sync_shift_port_test.sv
module sync_shift_port_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       bus_wr;
  logic       bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       sdata_in, sdata_out, sdata_oe;
  logic       sclk_a_in, sclk_a_out, sclk_a_oe;
  logic       sclk_b_in, sclk_b_out, sclk_b_oe;
  logic       irq;

  logic ext_clk, ext_on_b, mode_ext, rx_bit, msb_cur, od_mode;
  logic [7:0] rx_cur;
  logic [7:0] cap_sr;
  int unsigned rx_base;
  int unsigned fall_total = 0;
  int unsigned cyc_now    = 0;
  int unsigned irq_total  = 0;
  int unsigned data_bad   = 0;
  int n_vec = 0;
  int n_bad = 0;
  logic pin_clk, pin_data;
  logic [2:0] rx_k;

  assign sclk_a_in = ext_on_b ? 1'b1 : ext_clk;
  assign sclk_b_in = ext_on_b ? ext_clk : 1'b1;
  assign sdata_in  = rx_bit;
  assign pin_clk   = mode_ext ? ext_clk :
                     (sclk_a_oe ? sclk_a_out : (sclk_b_oe ? sclk_b_out : 1'b1));
  assign pin_data  = sdata_oe ? sdata_out : 1'b1;
  assign rx_k      = 3'(fall_total - rx_base);

  sync_shift_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sdata_in(sdata_in), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
    .sclk_a_in(sclk_a_in), .sclk_a_out(sclk_a_out), .sclk_a_oe(sclk_a_oe),
    .sclk_b_in(sclk_b_in), .sclk_b_out(sclk_b_out), .sclk_b_oe(sclk_b_oe),
    .irq(irq)
  );

  // {control, transmit byte, byte returned by the far end}
  localparam logic [23:0] VEC [0:5] = '{
    24'h48A53C, 24'h695AC3, 24'hCA817E, 24'h5B0FF0, 24'hFE9669, 24'h4F0180
  };

  always @(posedge clk) cyc_now <= cyc_now + 1;
  always @(negedge clk) if (irq === 1'b1) irq_total <= irq_total + 1;

  always @(posedge pin_clk) begin
    cap_sr <= {pin_data, cap_sr[7:1]};
    if ((od_mode && sdata_oe && sdata_out) || (!od_mode && !sdata_oe))
      data_bad <= data_bad + 1;
  end

  always @(negedge pin_clk) begin
    rx_bit     <= msb_cur ? rx_cur[3'd7 - rx_k] : rx_cur[rx_k];
    fall_total <= fall_total + 1;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  function automatic int exp_period(input logic [2:0] c);
    case (c)
      3'd0: exp_period = 8;
      3'd1: exp_period = 16;
      3'd2: exp_period = 32;
      3'd3: exp_period = 64;
      3'd6: exp_period = 128;
      default: exp_period = 256;
    endcase
  endfunction

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_irq(input int limit);
    for (int g = 0; g < limit; g++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic setup(input logic [7:0] c, input logic [7:0] rx);
    msb_cur  = c[5];
    od_mode  = c[4];
    rx_cur   = rx;
    rx_base  = fall_total;
    ext_on_b = c[7];
  endtask

  task automatic run_int(input logic [7:0] c, input logic [7:0] tx,
                         input logic [7:0] rx, input logic inject);
    logic [7:0] r;
    int unsigned t0, ib, db, cyc;
    mode_ext = 1'b0;
    setup(c, rx);
    wr(1'b1, c);
    rd(1'b1, r);
    chk(r == c, "R1 control readback", r, c);
    chk(sclk_a_oe == (c[3] & c[6] & ~c[7]) && sclk_b_oe == (c[3] & c[6] & c[7]),
        "R8 clock pin steering", {sclk_a_oe, sclk_b_oe}, {c[3] & c[6] & ~c[7], c[3] & c[6] & c[7]});
    ib = irq_total; db = data_bad;
    wr(1'b0, tx);
    t0 = cyc_now;
    if (inject) begin
      repeat (20) @(negedge clk);
      wr(1'b0, 8'hFF);  // R13: must be ignored
    end
    wait_irq(6000);
    cyc = cyc_now - t0;
    repeat (2) @(negedge clk);
    chk(cyc == 32'(8 * exp_period(c[2:0])), "R2/R4 write-to-irq cycles", cyc,
        8 * exp_period(c[2:0]));
    rd(1'b0, r);
    chk(r == rx, inject ? "R13 received byte after ignored write" : "R6 received byte", r, rx);
    chk(cap_sr == (c[5] ? rev8(tx) : tx), inject ? "R13 transmitted bits" : "R5 transmitted bits",
        cap_sr, c[5] ? rev8(tx) : tx);
    chk(irq_total - ib == 1, "R12 one irq pulse", irq_total - ib, 1);
    chk(data_bad == db, "R10 data pin drive mode", data_bad - db, 0);
    chk(pin_clk == 1'b1, "R7 clock idles high", pin_clk, 1);
  endtask

  task automatic run_ext(input logic [7:0] c, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] r;
    int unsigned ib, oe_seen;
    mode_ext = 1'b1;
    ext_clk  = 1'b1;
    setup(c, rx);
    wr(1'b1, c);
    ib = irq_total; oe_seen = 0;
    wr(1'b0, tx);
    repeat (50) @(negedge clk);
    rd(1'b0, r);
    chk(r == tx && irq_total == ib, "R11 no shift without external edges", r, tx);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk) ext_clk = 1'b0;
      for (int h = 0; h < 8; h++) begin
        @(negedge clk);
        if (sclk_a_oe || sclk_b_oe) oe_seen++;
      end
      ext_clk = 1'b1;
      for (int h = 0; h < 8; h++) begin
        @(negedge clk);
        if (sclk_a_oe || sclk_b_oe) oe_seen++;
      end
    end
    repeat (4) @(negedge clk);
    rd(1'b0, r);
    chk(r == rx, "R11 external received byte", r, rx);
    chk(cap_sr == (c[5] ? rev8(tx) : tx), "R11 external transmitted bits", cap_sr,
        c[5] ? rev8(tx) : tx);
    chk(irq_total - ib == 1, "R11/R12 external irq pulse", irq_total - ib, 1);
    chk(oe_seen == 0, "R11 clock pins undriven", oe_seen, 0);
    mode_ext = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec + 1, n_bad + 1);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int unsigned lows, irqs, oes, ib, t0;
    bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
    ext_clk = 1'b1; ext_on_b = 1'b0; mode_ext = 1'b0;
    msb_cur = 1'b0; od_mode = 1'b0; rx_cur = 8'h00; rx_base = 0;
    do_reset();

    // R1 reset state
    rd(1'b1, r);
    chk(r == 8'h00, "R1 control reset value", r, 8'h00);
    chk(!sdata_oe && !sclk_a_oe && !sclk_b_oe && !irq, "R1 pins idle after reset",
        {sdata_oe, sclk_a_oe, sclk_b_oe, irq}, 0);

    // Table of internal-clock transfers
    for (int i = 0; i < 6; i++)
      run_int(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], 1'b0);

    // R13 write during a transfer
    run_int(8'h48, 8'hA5, 8'h3C, 1'b1);

    // R9 port disabled: no pin driven, transfer still completes
    wr(1'b1, 8'h40);
    oes = 0; ib = irq_total;
    wr(1'b0, 8'hC3);
    t0 = cyc_now;
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      if (sdata_oe || sclk_a_oe || sclk_b_oe) oes++;
      if (irq) break;
    end
    chk(oes == 0, "R9 outputs undriven with port off", oes, 0);
    chk(cyc_now - t0 == 64, "R9/R4 transfer completes with port off", cyc_now - t0, 64);

    // External clock on pin A (LSB first) and pin B (MSB first)
    run_ext(8'h08, 8'h6B, 8'hD4);
    run_ext(8'hA8, 8'h2E, 8'h91);

    // R3 reserved divider code
    wr(1'b1, 8'h4C);
    wr(1'b0, 8'h55);
    lows = 0; irqs = 0;
    for (int g = 0; g < 3000; g++) begin
      @(negedge clk);
      if (!sclk_a_out) lows++;
      if (irq) irqs++;
    end
    chk(lows == 0 && irqs == 0, "R3 reserved code gives no clock", lows + irqs, 0);
    rd(1'b0, r);
    chk(r == 8'h55, "R3 data register unshifted", r, 8'h55);
    do_reset();

    // R1 reset in the middle of a transfer
    wr(1'b1, 8'h48);
    wr(1'b0, 8'hE7);
    repeat (20) @(negedge clk);
    do_reset();
    rd(1'b1, r);
    chk(r == 8'h00, "R1 control cleared by reset", r, 8'h00);
    rd(1'b0, r);
    chk(r == 8'h00, "R1 data cleared by reset", r, 8'h00);
    ib = irq_total;
    repeat (100) @(negedge clk);
    chk(irq_total == ib && !sclk_a_oe && !sdata_oe, "R1 transfer stopped by reset",
        irq_total - ib, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule